// File: doc/BRIEF.md
# Input Supply Loss Detector

This block watches a stream of digitised samples of the main input supply and decides when the supply has really been lost. A nominal 12 V input may legitimately move within ±10%. The trip level is therefore placed slightly below the lower edge of that band, and not at nominal. A single low reading is not enough to trip the block. A loss is declared only after a configurable number of consecutive valid samples all read below the trip level. Short dips and glitches are rejected this way.

When a loss is declared, two outputs change on the same clock edge. The block raises a shutdown request for the power sequencer and pulls its active-low device reset output low. Both outputs come from the same latched loss flag. The flag holds until an explicit clear is given. The clear is honoured only while the most recent valid sample reads healthy again.

Top module: `supply_loss_det`

## Requirements
- R1: After reset, `loss_o` is 0, `shutdown_req_o` is 0 and `dev_rst_no` is 1.
- R2: A valid sample whose value is strictly less than `trip_level_i` extends the run of low samples. On the clock edge that captures the Nth consecutive low sample, where N is `run_len_i` (1 to 15), `loss_o` becomes 1.
- R3: A valid sample whose value is greater than or equal to `trip_level_i` resets the run to zero. A sample exactly at the trip level counts as healthy.
- R4: A cycle with `smp_valid_i` low neither extends nor resets the run, whatever the value on `smp_data_i`.
- R5: Once set, `loss_o` stays 1 on every later edge until a clear is accepted.
- R6: `clear_i` is accepted only when the most recent valid sample was healthy. Before any sample has arrived after reset, the supply is treated as healthy. An accepted clear drops `loss_o` to 0 on that edge and resets the run to zero. A clear given while the latest valid sample was low is ignored.
- R7: `shutdown_req_o` equals `loss_o`, and `dev_rst_no` equals its inverse, in every cycle.
- R8: A `run_len_i` of 0 behaves as 1: a single low sample trips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | SMP_W | Supply sample value |
| trip_level_i | input | SMP_W | Undervoltage trip level |
| run_len_i | input | 4 | Consecutive low samples required |
| clear_i | input | 1 | Request to clear a latched loss |
| loss_o | output | 1 | Latched loss flag |
| shutdown_req_o | output | 1 | Shutdown trigger to the sequencer |
| dev_rst_no | output | 1 | Device reset, active low |

## Verification
The qualification logic is tried with several sample patterns:
- Low runs broken by a healthy sample show that one good reading restarts the count.
- Runs interleaved with idle strobes carrying low data show that idle cycles are transparent.
- A sample exactly at the trip level separates the strict "below" comparison from "at or below".

The extreme run lengths 0, 1 and 15 are tried, to confirm the exact edge on which the flag trips. Clears are given both while the supply still reads low and after it recovers, so that a clear which is ignored can be told apart from one that is honoured.

// File: rtl/supply_loss_pkg.sv
package supply_loss_pkg;
  localparam int unsigned RUN_W   = 4;
  localparam int unsigned RUN_MAX = (1 << RUN_W) - 1;
  typedef logic [RUN_W-1:0] run_t;
endpackage

// File: rtl/low_run_counter.sv
module low_run_counter
  import supply_loss_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic below_i,
  input  logic clr_i,
  input  run_t run_len_i,
  output logic hit_o
);
  run_t cnt_q;
  run_t len_eff;
  logic [RUN_W:0] cnt_next;

  assign len_eff  = (run_len_i == '0) ? run_t'(1) : run_len_i;  // R8
  assign cnt_next = {1'b0, cnt_q} + {{RUN_W{1'b0}}, 1'b1};
  assign hit_o    = valid_i && below_i && (cnt_next >= {1'b0, len_eff});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (valid_i) begin
      if (!below_i)                  cnt_q <= '0;
      else if (cnt_q != run_t'(RUN_MAX)) cnt_q <= cnt_q + run_t'(1);
    end
  end

  a_r4_idle_holds_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clr_i) |=> $stable(cnt_q));
  a_r3_healthy_clears_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !below_i) |=> (cnt_q == '0));
endmodule

// File: rtl/loss_latch.sv
module loss_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic below_i,
  input  logic set_i,
  input  logic clear_i,
  output logic clr_ok_o,
  output logic loss_o
);
  logic loss_q;
  logic healthy_q;

  assign clr_ok_o = clear_i && healthy_q && !set_i;
  assign loss_o   = loss_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loss_q    <= 1'b0;
      healthy_q <= 1'b1;
    end else begin
      if (valid_i) healthy_q <= !below_i;
      if (set_i)         loss_q <= 1'b1;
      else if (clr_ok_o) loss_q <= 1'b0;
    end
  end

  a_r5_loss_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loss_q && !clear_i) |=> loss_q);
  a_r6_clear_needs_healthy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(loss_q) |-> $past(clear_i && healthy_q));
endmodule

// File: rtl/supply_loss_det.sv
module supply_loss_det
  import supply_loss_pkg::*;
#(
  parameter int unsigned SMP_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_data_i,
  input  logic [SMP_W-1:0] trip_level_i,
  input  logic [RUN_W-1:0] run_len_i,
  input  logic             clear_i,
  output logic             loss_o,
  output logic             shutdown_req_o,
  output logic             dev_rst_no
);
  logic below;
  logic hit;
  logic clr_ok;
  logic loss;

  assign below = smp_data_i < trip_level_i;

  low_run_counter u_run (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (smp_valid_i),
    .below_i   (below),
    .clr_i     (clr_ok),
    .run_len_i (run_len_i),
    .hit_o     (hit)
  );

  loss_latch u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (smp_valid_i),
    .below_i  (below),
    .set_i    (hit),
    .clear_i  (clear_i),
    .clr_ok_o (clr_ok),
    .loss_o   (loss)
  );

  // R7: both consumers see the same edge
  assign loss_o         = loss;
  assign shutdown_req_o = loss;
  assign dev_rst_no     = ~loss;

  a_r2_trip_needs_low_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(loss_o) |-> $past(smp_valid_i && (smp_data_i < trip_level_i)));
endmodule

// File: tb/supply_loss_det_tb.sv
module supply_loss_det_tb_top;
  localparam int W = 12;
  localparam logic [W-1:0] TRIP = 12'h700;
  localparam logic [W-1:0] LOW  = 12'h600;
  localparam logic [W-1:0] HIGH = 12'h7FF;
  localparam int NV = 11;
  // {valid, clear, expected loss, data}, run length 3
  localparam logic [W+2:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, LOW},   // R2 run 1
    {1'b1, 1'b0, 1'b0, LOW},   // R2 run 2
    {1'b1, 1'b0, 1'b0, HIGH},  // R3 run reset
    {1'b1, 1'b0, 1'b0, LOW},
    {1'b1, 1'b0, 1'b0, LOW},
    {1'b0, 1'b0, 1'b0, LOW},   // R4 idle with low data
    {1'b1, 1'b0, 1'b1, LOW},   // R2 third low trips
    {1'b0, 1'b1, 1'b1, HIGH},  // R6 clear while low ignored
    {1'b1, 1'b0, 1'b1, TRIP},  // R3/R5 equal is healthy, flag held
    {1'b0, 1'b1, 1'b0, LOW},   // R6 clear honoured
    {1'b1, 1'b0, 1'b0, LOW}    // R6 run restarted by clear
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic smp_valid_i = 1'b0;
  logic [W-1:0] smp_data_i = '0;
  logic [W-1:0] trip_level_i = TRIP;
  logic [3:0] run_len_i = 4'd3;
  logic clear_i = 1'b0;
  logic loss_o, shutdown_req_o, dev_rst_no;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  supply_loss_det #(.SMP_W(W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_valid_i(smp_valid_i),
    .smp_data_i(smp_data_i), .trip_level_i(trip_level_i),
    .run_len_i(run_len_i), .clear_i(clear_i), .loss_o(loss_o),
    .shutdown_req_o(shutdown_req_o), .dev_rst_no(dev_rst_no)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic chk_r7();
    chk("R7 shutdown", shutdown_req_o, loss_o);
    chk("R7 reset_n", dev_rst_no, ~loss_o);
  endtask

  task automatic step(input logic v, input logic c, input logic [W-1:0] d);
    @(negedge clk_i);
    smp_valid_i = v; clear_i = c; smp_data_i = d;
    @(posedge clk_i); #1;
    @(negedge clk_i);
    smp_valid_i = 1'b0; clear_i = 1'b0;
  endtask

  task automatic recover();
    step(1'b1, 1'b0, HIGH);
    step(1'b0, 1'b1, LOW);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 loss", loss_o, 1'b0);
    chk("R1 shutdown", shutdown_req_o, 1'b0);
    chk("R1 reset_n", dev_rst_no, 1'b1);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][W+2], VEC[i][W+1], VEC[i][W-1:0]);
      chk($sformatf("R2-vector %0d", i), loss_o, VEC[i][W]);
      chk_r7();
    end
    recover();

    // R8: length 0 acts as 1
    run_len_i = 4'd0;
    step(1'b1, 1'b0, LOW);
    chk("R8 zero length trips", loss_o, 1'b1);
    recover();
    chk("R6 recovered", loss_o, 1'b0);

    // length 1
    run_len_i = 4'd1;
    step(1'b1, 1'b0, TRIP);
    chk("R3 equal no trip", loss_o, 1'b0);
    step(1'b1, 1'b0, TRIP - 1'b1);
    chk("R2 one below trips", loss_o, 1'b1);
    chk_r7();
    recover();

    // length 15
    run_len_i = 4'd15;
    for (int k = 0; k < 14; k++) step(1'b1, 1'b0, LOW);
    chk("R2 fourteen of fifteen", loss_o, 1'b0);
    step(1'b1, 1'b0, LOW);
    chk("R2 fifteenth trips", loss_o, 1'b1);
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0, HIGH);
    chk("R5 held without clear", loss_o, 1'b1);
    step(1'b0, 1'b1, LOW);
    chk("R6 clear after recovery", loss_o, 1'b0);
    chk_r7();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule